// File: doc/BRIEF.md
# Three-by-three sliding window generator with rotating line stores

This block turns a raster-ordered pixel stream into a stream of 3x3 pixel neighbourhoods for a filtering datapath. Pixels come in one per accepted cycle on a valid/ready port. Each image row goes into one of three line stores whose depth is the image width. When three rows are held, the block scans them column by column. Each step reads one pixel from every store at the same column and shifts that column into a 3x3 register array. Once three columns are present, a full neighbourhood appears on the output with a valid flag.

The line stores form a circular queue. A head pointer names the store that holds the oldest (top) row. When a row of windows is finished, the head advances by one. The top store becomes free and takes the next incoming row, so no row is ever copied. After the configured number of rows has been consumed, the queue is emptied and the next frame starts with a fresh fill of three rows. Input and output phases alternate: rows load while no windows are produced, and no input is taken while a row of windows is scanned. The output can be stalled.

Top module: `linebuf_win3`

## Requirements
- R1: Right after reset, `in_ready` is 1 and `win_valid` is 0.
- R2: A pixel is taken only in a cycle where `in_valid` and `in_ready` are both 1, in raster order. `in_ready` is 1 only while a row is being loaded and is never 1 together with `win_valid`. A pixel offered while `in_ready` is 0 has no effect.
- R3: No window is produced until three complete rows of the current frame have been loaded.
- R4: Window pixel k = 3*r + c sits at `win_pix[k*PIX_W +: PIX_W]`. It holds the pixel in column (s+c) of the r-th oldest stored row, where s is the window's start column and r = 0 is the top (oldest) row.
- R5: Each row scan produces exactly IMG_W-2 windows with start columns 0, 1, …, IMG_W-3 in order. No window mixes columns from two scans.
- R6: After the last window of a scan is taken, `win_valid` drops and `in_ready` rises. The next row replaces the oldest stored row. The following windows use the former middle and bottom rows as their top and middle rows, and the new row as the bottom row.
- R7: While `win_valid` is 1 and `win_ready` is 0, `win_valid` and `win_pix` hold unchanged.
- R8: After the scan that uses the IMG_H-th row of a frame, all stored rows are dropped. The next frame again needs three full rows before its first window, so no window spans two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; deassertion must be synchronous to clk |
| in_valid | input | 1 | Input pixel is offered |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| in_pixel | input | PIX_W | Input pixel, raster order |
| win_ready | input | 1 | Consumer takes the window this cycle |
| win_valid | output | 1 | Window output is valid |
| win_pix | output | 9*PIX_W | Nine window pixels, index 3*row+col |

## Verification
The hardest situations to reach from the ports are a stall that lands exactly on the last window of a scan, and the point where the third rotation of the head pointer meets the frame boundary. Reaching either needs hundreds of accepted pixels with the right timing. The stimulus runs several full frames in three regimes: everything always ready, random gaps on both sides, and a consumer that is mostly stalled. A behavioural model that keeps the last three rows as plain arrays predicts every output each cycle, so these rare alignments are checked whenever they occur.

// File: rtl/linebuf_pkg.sv
package linebuf_pkg;
  localparam int unsigned WIN_N = 3;

  typedef enum logic {PH_LOAD = 1'b0, PH_SCAN = 1'b1} phase_e;

  // modulo-3 sum of two slot indices
  function automatic logic [1:0] slot_add(input logic [1:0] a, input logic [1:0] b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction
endpackage

// File: rtl/lbw_ctrl.sv
module lbw_ctrl
  import linebuf_pkg::*;
#(
  parameter int unsigned IMG_W = 8,
  parameter int unsigned IMG_H = 6,
  localparam int unsigned AW = $clog2(IMG_W),
  localparam int unsigned CW = $clog2(IMG_W + 1),
  localparam int unsigned RW = $clog2(IMG_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          win_ready,
  output logic          in_ready,
  output logic          win_valid,
  output logic          wr_en,
  output logic [1:0]    wr_slot,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          shift_en,
  output logic          clr,
  output logic [1:0]    head,
  output logic [1:0]    fill
);
  phase_e        ph_q, ph_n;
  logic [AW-1:0] wcol_q, wcol_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [RW-1:0] frow_q, frow_n;
  logic [1:0]    fill_q, fill_n, head_q, head_n;
  logic          acc, adv, row_done;

  always_comb begin
    in_ready  = (ph_q == PH_LOAD);
    win_valid = (ph_q == PH_SCAN) && (cnt_q >= CW'(WIN_N));
    acc       = in_valid && in_ready;
    adv       = (ph_q == PH_SCAN) && (!win_valid || win_ready);
    shift_en  = adv && (cnt_q < CW'(IMG_W));
    row_done  = adv && (cnt_q == CW'(IMG_W));
    clr       = row_done;
    wr_en     = acc;
    wr_slot   = slot_add(head_q, fill_q);
    wr_addr   = wcol_q;
    rd_addr   = AW'(cnt_q);
    head      = head_q;
    fill      = fill_q;

    ph_n   = ph_q;
    wcol_n = wcol_q;
    cnt_n  = cnt_q;
    frow_n = frow_q;
    fill_n = fill_q;
    head_n = head_q;
    if (acc) begin
      if (wcol_q == AW'(IMG_W - 1)) begin
        wcol_n = '0;
        fill_n = fill_q + 2'd1;
        frow_n = frow_q + RW'(1);
        if (fill_q == 2'd2) ph_n = PH_SCAN;
      end else begin
        wcol_n = wcol_q + AW'(1);
      end
    end
    if (shift_en) cnt_n = cnt_q + CW'(1);
    if (row_done) begin
      cnt_n = '0;
      ph_n  = PH_LOAD;
      if (frow_q == RW'(IMG_H)) begin
        fill_n = 2'd0;
        frow_n = '0;
      end else begin
        fill_n = 2'd2;
        head_n = slot_add(head_q, 2'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_LOAD;
      wcol_q <= '0;
      cnt_q  <= '0;
      frow_q <= '0;
      fill_q <= 2'd0;
      head_q <= 2'd0;
    end else begin
      ph_q   <= ph_n;
      wcol_q <= wcol_n;
      cnt_q  <= cnt_n;
      frow_q <= frow_n;
      fill_q <= fill_n;
      head_q <= head_n;
    end
  end
endmodule

// File: rtl/lbw_rowstore.sv
module lbw_rowstore
  import linebuf_pkg::*;
#(
  parameter int unsigned IMG_W = 8,
  parameter int unsigned PIX_W = 8,
  localparam int unsigned AW = $clog2(IMG_W)
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_slot,
  input  logic [AW-1:0]               wr_addr,
  input  logic [PIX_W-1:0]            wr_data,
  input  logic [AW-1:0]               rd_addr,
  input  logic [1:0]                  head,
  output logic [WIN_N-1:0][PIX_W-1:0] col_o
);
  logic [PIX_W-1:0] rd_col [WIN_N];

  for (genvar s = 0; s < WIN_N; s++) begin : g_line
    logic [PIX_W-1:0] mem [IMG_W];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_slot == 2'(s))) mem[wr_addr] <= wr_data;
    end
    assign rd_col[s] = mem[rd_addr];
  end

  // logical row r (0 = oldest) lives in physical store head+r
  always_comb begin
    for (int r = 0; r < WIN_N; r++) col_o[r] = rd_col[slot_add(head, 2'(r))];
  end
endmodule

// File: rtl/lbw_winshift.sv
module lbw_winshift
  import linebuf_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              shift_en,
  input  logic                              clr,
  input  logic [WIN_N-1:0][PIX_W-1:0]       col_i,
  output logic [WIN_N*WIN_N-1:0][PIX_W-1:0] win_o
);
  logic [WIN_N*WIN_N-1:0][PIX_W-1:0] win_q, win_n;

  always_comb begin
    win_n = win_q;
    if (clr) begin
      win_n = '0;
    end else if (shift_en) begin
      for (int r = 0; r < WIN_N; r++) begin
        for (int c = 0; c < WIN_N - 1; c++) win_n[r*WIN_N + c] = win_q[r*WIN_N + c + 1];
        win_n[r*WIN_N + WIN_N - 1] = col_i[r];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_n;
  end

  assign win_o = win_q;
endmodule

// File: rtl/linebuf_win3.sv
module linebuf_win3
  import linebuf_pkg::*;
#(
  parameter int unsigned IMG_W = 8,
  parameter int unsigned IMG_H = 6,
  parameter int unsigned PIX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PIX_W-1:0]     in_pixel,
  input  logic                 win_ready,
  output logic                 win_valid,
  output logic [9*PIX_W-1:0]   win_pix
);
  localparam int unsigned AW = $clog2(IMG_W);

  logic                              wr_en, shift_en, clr;
  logic [1:0]                        wr_slot, head_w, fill_w;
  logic [AW-1:0]                     wr_addr, rd_addr;
  logic [WIN_N-1:0][PIX_W-1:0]       col;
  logic [WIN_N*WIN_N-1:0][PIX_W-1:0] win;

  lbw_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .win_ready(win_ready),
    .in_ready(in_ready), .win_valid(win_valid), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .shift_en(shift_en), .clr(clr),
    .head(head_w), .fill(fill_w)
  );

  lbw_rowstore #(.IMG_W(IMG_W), .PIX_W(PIX_W)) i_store (
    .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_addr(wr_addr),
    .wr_data(in_pixel), .rd_addr(rd_addr), .head(head_w), .col_o(col)
  );

  lbw_winshift #(.PIX_W(PIX_W)) i_win (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .clr(clr),
    .col_i(col), .win_o(win)
  );

  assign win_pix = win;
endmodule

// File: rtl/lbw_chk.sv
module lbw_chk #(
  parameter int unsigned PIX_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               win_valid,
  input logic               win_ready,
  input logic [9*PIX_W-1:0] win_pix,
  input logic [1:0]         fill,
  input logic [1:0]         head
);
  a_r2_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && win_valid));

  a_r3_three_rows: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (fill == 2'd3));

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_ready) |=> (win_valid && $stable(win_pix)));

  a_r6_head_range: assert property (@(posedge clk) disable iff (!rst_n)
    head <= 2'd2);

  a_r6_room_to_load: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (fill < 2'd3));

  a_r6_reload_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_valid) |-> in_ready);
endmodule

bind linebuf_win3 lbw_chk #(.PIX_W(PIX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .win_valid(win_valid),
  .win_ready(win_ready), .win_pix(win_pix), .fill(fill_w), .head(head_w)
);

// File: tb/test_linebuf_win3.sv
module test_linebuf_win3;
  localparam int W = 8;
  localparam int H = 6;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, win_ready, win_valid;
  logic [PW-1:0] in_pixel;
  logic [9*PW-1:0] win_pix;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  linebuf_win3 #(.IMG_W(W), .IMG_H(H), .PIX_W(PW)) i_linebuf_win3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .win_ready(win_ready), .win_valid(win_valid), .win_pix(win_pix)
  );

  // behavioural model: last three rows as plain arrays
  int rb [3][W];
  int nrows = 0, wc = 0, frows = 0, sc = 0, frames = 0, win_in_row = 0;
  bit scan = 0;
  bit prev_stall = 0;
  logic [9*PW-1:0] prev_pix;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    bit ev;
    string t;
    ev = scan && (sc >= 3);
    t = (frows > 3 || (frows == 3 && !scan)) ? "R6 in_ready" : "R2 in_ready";
    chk(in_ready == !scan, t, in_ready, !scan);
    t = (frames > 0 && nrows < 3) ? "R8 win_valid" : "R3 win_valid";
    chk(win_valid == ev, t, win_valid, ev);
    if (ev && win_valid) begin
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++) begin
          int k;
          int e;
          k = r * 3 + c;
          e = rb[r][sc - 3 + c];
          chk(win_pix[k*PW +: PW] == PW'(e), "R4 window pixel", win_pix[k*PW +: PW], e);
        end
    end
    if (prev_stall) chk(win_valid && win_pix == prev_pix, "R7 stall hold", win_pix, prev_pix);
  endtask

  task automatic step(input int pv, input int pr);
    bit ev;
    compare();
    ev = scan && (sc >= 3);
    in_valid  = ($urandom_range(99) < pv);
    in_pixel  = PW'($urandom);
    win_ready = ($urandom_range(99) < pr);
    prev_stall = win_valid && !win_ready;
    prev_pix   = win_pix;
    if (win_valid && win_ready) win_in_row++;
    if (!scan) begin
      if (in_valid) begin
        rb[nrows][wc] = int'(in_pixel);
        wc++;
        if (wc == W) begin
          wc = 0; nrows++; frows++;
          if (nrows == 3) scan = 1;
        end
      end
    end else if (!ev || win_ready) begin
      if (sc < W) sc++;
      else begin
        chk(win_in_row == W - 2, "R5 windows per scan", win_in_row, W - 2);
        win_in_row = 0; sc = 0; scan = 0;
        if (frows == H) begin
          nrows = 0; frows = 0; frames++;
        end else begin
          for (int c = 0; c < W; c++) begin
            rb[0][c] = rb[1][c];
            rb[1][c] = rb[2][c];
          end
          nrows = 2;
        end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_pixel = '0; win_ready = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(win_valid == 1'b0, "R1 win_valid after reset", win_valid, 0);
    for (int i = 0; i < 800; i++)  step(100, 100);
    for (int i = 0; i < 1500; i++) step(70, 60);
    for (int i = 0; i < 1500; i++) step(100, 20);
    chk(frames >= 3, "R8 frames completed", frames, 3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule